// File: doc/BRIEF.md
# Serial Power-Switch Control Shifter

This block delivers socket supply requests to an external two-socket card power switch over a three-wire serial link: a shift clock, a data line and a latch strobe. The host presents the wanted supply settings for both sockets, a main-rail (VCC) code and a programming-rail (VPP) code per socket, and pulses a request strobe. The block packs the four codes into one 11-bit word and shifts it out MSB first. The data line only changes on falling edges of the shift clock, so the switch can sample it on rising edges. A latch pulse then tells the switch to apply the word.

The shift clock has two sources. When the drive-enable input is low, the clock pin is an input. An external clock on it is synchronized to the bus clock and its falling edges pace the shifter. When drive-enable is high, the block drives the pin itself from a divider of the bus clock. By default the divider is 36, which keeps the link under 2 MHz for a 33 MHz bus. A request that arrives during a transfer is held and sent after the current latch pulse. A busy output covers the whole time a request is queued or in flight.

Top module: `pwrsw_serial_ctl`

## Requirements
- R1: After reset, sw_latch, sw_data, sw_clk_out, sw_clk_oe and busy are all 0.
- R2: sw_clk_oe equals clk_drive_en. While clk_drive_en is 0, sw_clk_out is 0.
- R3: With clk_drive_en high, sw_clk_out is periodic with a period of DIV bus cycles (36 by default): low for DIV/2 cycles, then high for the rest.
- R4: A frame is 11 bits sent MSB first. Bit 10 is a 0 pad. Bits 9:7 carry b_vcc, bits 6:5 b_vpp, bits 4:2 a_vcc and bits 1:0 a_vpp, all as captured with req_valid.
- R5: sw_latch rises at the first shift-clock falling edge after the last bit has been presented. It stays high for exactly one shift-clock period (DIV bus cycles when internal, one external period when external), then returns low.
- R6: sw_data changes only at shift-clock falling edges, so it is stable for the whole high phase of the shift clock.
- R7: busy goes high the cycle after req_valid. It stays high while a request is pending or a frame or latch pulse is in progress, and is 0 once the latch falls with nothing queued.
- R8: A request made during a transfer is sent as the next frame after the current latch pulse. If several arrive meanwhile, only the last one is sent.
- R9: With clk_drive_en low, a frame is shifted on the falling edges of sw_clk_in after a two-flop synchronizer, and it carries the same content and latch timing as in R4 and R5.
- R10: Without req_valid, no latch pulse is produced and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_drive_en | input | 1 | 1: block drives the shift clock; 0: shift clock is an input |
| req_valid | input | 1 | One-cycle strobe that captures a new request |
| b_vcc | input | 3 | Socket B main-rail code |
| b_vpp | input | 2 | Socket B programming-rail code |
| a_vcc | input | 3 | Socket A main-rail code |
| a_vpp | input | 2 | Socket A programming-rail code |
| sw_clk_in | input | 1 | Shift clock from outside, used when not driving |
| sw_clk_out | output | 1 | Internally divided shift clock |
| sw_clk_oe | output | 1 | Output enable for the shift-clock pin |
| sw_data | output | 1 | Serial data to the power switch |
| sw_latch | output | 1 | Latch strobe committing the shifted word |
| busy | output | 1 | Request pending or transfer in progress |

## Verification
On every cycle, the assertions check the following:
- the data line moves only on a shift tick;
- the latch rises only on the tick after the last bit and falls only on a tick;
- busy covers the latch pulse;
- a frame starts only from a held request;
- the divided clock changes level only at its fixed counter points;
- external falling-edge ticks never come back to back.

Only the bench scenarios can show the following:
- the word the switch would receive, bit for bit;
- that the last of several queued requests wins;
- the exact latch width in both clock modes;
- that an idle link stays quiet.

// File: rtl/pwrsw_pkg.sv
package pwrsw_pkg;
  localparam int VCC_W   = 3;
  localparam int VPP_W   = 2;
  localparam int PAD_W   = 1;
  localparam int SOCK_W  = VCC_W + VPP_W;
  localparam int FRAME_W = PAD_W + 2 * SOCK_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } shift_state_t;

  // Word layout: pad, socket B (vcc, vpp), socket A (vcc, vpp); MSB goes first.
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [VCC_W-1:0] bvcc, input logic [VPP_W-1:0] bvpp,
    input logic [VCC_W-1:0] avcc, input logic [VPP_W-1:0] avpp);
    return {{PAD_W{1'b0}}, bvcc, bvpp, avcc, avpp};
  endfunction

  function automatic int low_phase(input int div);
    return div / 2;
  endfunction
endpackage

// File: rtl/pwrsw_clkdiv.sv
module pwrsw_clkdiv #(
  parameter int DIV = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic fall_tick
);
  localparam int HALF  = pwrsw_pkg::low_phase(DIV);
  localparam int CNT_W = $clog2(DIV);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] CNT_RISE = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             sclk_q;
  logic             rise_tick;

  assign rise_tick = en && (cnt == CNT_RISE);
  assign fall_tick = en && (cnt == CNT_LAST);
  assign sclk      = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + 1'b1;
      if (rise_tick)      sclk_q <= 1'b1;
      else if (fall_tick) sclk_q <= 1'b0;
    end
  end

  AST_DIV_FALL_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_q) && $past(en)) |-> ($past(cnt) == CNT_LAST)); // R3
  AST_DIV_RISE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> ($past(cnt) == CNT_RISE)); // R3
endmodule

// File: rtl/pwrsw_edge_src.sv
module pwrsw_edge_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_en,
  input  logic ext_clk,
  input  logic int_tick,
  output logic shift_tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_fall;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= ext_clk;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign ext_fall   = prev_q && !sync_q[SYNC_STAGES-1];
  assign shift_tick = drv_en ? int_tick : ext_fall;

  AST_EXT_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en && shift_tick) |=> !ext_fall); // R9
endmodule

// File: rtl/pwrsw_shifter.sv
module pwrsw_shifter
  import pwrsw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [FRAME_W-1:0] req_frame,
  input  logic               tick,
  output logic               sw_data,
  output logic               sw_latch,
  output logic               busy
);
  localparam int BC_W = $clog2(FRAME_W);
  localparam logic [BC_W-1:0] BC_TOP = BC_W'(FRAME_W - 1);

  shift_state_t       state;
  logic [FRAME_W-1:0] sr;
  logic [BC_W-1:0]    bits_left;
  logic               latch_q;
  logic               pend_v;
  logic [FRAME_W-1:0] pend_f;
  logic               start_evt;

  assign start_evt = tick && (state == ST_IDLE) && pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sr        <= '0;
      bits_left <= '0;
      latch_q   <= 1'b0;
      pend_v    <= 1'b0;
      pend_f    <= '0;
    end else begin
      if (req_valid) begin
        pend_v <= 1'b1;
        pend_f <= req_frame;
      end else if (start_evt) begin
        pend_v <= 1'b0;
      end
      if (tick) begin
        unique case (state)
          ST_IDLE: if (pend_v) begin
            sr        <= pend_f;
            bits_left <= BC_TOP;
            state     <= ST_SHIFT;
          end
          ST_SHIFT: if (bits_left == '0) begin
            state   <= ST_LATCH;
            latch_q <= 1'b1;
          end else begin
            sr        <= sr << 1;
            bits_left <= bits_left - 1'b1;
          end
          ST_LATCH: begin
            latch_q <= 1'b0;
            sr      <= '0;
            state   <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sw_data  = sr[FRAME_W-1];
  assign sw_latch = latch_q;
  assign busy     = pend_v || (state != ST_IDLE);

  AST_DATA_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_data) |-> $past(tick)); // R6
  AST_LATCH_RISE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_latch) |-> ($past(tick) && $past(bits_left) == '0)); // R5
  AST_LATCH_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_latch) |-> $past(tick)); // R5
  AST_BUSY_COVERS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sw_latch |-> busy); // R7
  AST_START_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && $past(state) == ST_IDLE) |-> $past(pend_v)); // R8
endmodule

// File: rtl/pwrsw_serial_ctl.sv
module pwrsw_serial_ctl
  import pwrsw_pkg::*;
#(
  parameter int DIV         = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_drive_en,
  input  logic             req_valid,
  input  logic [VCC_W-1:0] b_vcc,
  input  logic [VPP_W-1:0] b_vpp,
  input  logic [VCC_W-1:0] a_vcc,
  input  logic [VPP_W-1:0] a_vpp,
  input  logic             sw_clk_in,
  output logic             sw_clk_out,
  output logic             sw_clk_oe,
  output logic             sw_data,
  output logic             sw_latch,
  output logic             busy
);
  logic               int_sclk;
  logic               int_fall;
  logic               shift_tick;
  logic [FRAME_W-1:0] req_frame;

  assign req_frame  = build_frame(b_vcc, b_vpp, a_vcc, a_vpp);
  assign sw_clk_oe  = clk_drive_en;
  assign sw_clk_out = int_sclk;

  pwrsw_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(clk_drive_en),
    .sclk(int_sclk), .fall_tick(int_fall)
  );

  pwrsw_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .drv_en(clk_drive_en), .ext_clk(sw_clk_in),
    .int_tick(int_fall), .shift_tick(shift_tick)
  );

  pwrsw_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_frame(req_frame),
    .tick(shift_tick), .sw_data(sw_data), .sw_latch(sw_latch), .busy(busy)
  );

  AST_OUT_QUIET_WHEN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_drive_en && $past(!clk_drive_en)) |-> !sw_clk_out); // R2
endmodule

// File: tb/pwrsw_serial_ctl_tb.sv
module pwrsw_serial_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 36;
  localparam int EXT_HALF   = 10;
  localparam int TMO        = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_drive_en = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] b_vcc = '0, a_vcc = '0;
  logic [1:0] b_vpp = '0, a_vpp = '0;
  logic ext_clk = 1'b0;
  logic ext_run = 1'b0;
  logic sw_clk_out, sw_clk_oe, sw_data, sw_latch, busy;
  logic link_clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  int frames_seen = 0;
  logic [10:0] rx_sr = '0;
  logic [10:0] fr_log [8];
  logic lc_prev = 1'b0, latch_prev = 1'b0, rise_data = 1'b0;
  int last_rise = -1, rise_gap = 0, high_len = 0, lat_cnt = 0, latch_w = 0;
  int stable_viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrsw_serial_ctl #(.DIV(DIV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_drive_en(clk_drive_en), .req_valid(req_valid),
    .b_vcc(b_vcc), .b_vpp(b_vpp), .a_vcc(a_vcc), .a_vpp(a_vpp),
    .sw_clk_in(ext_clk), .sw_clk_out(sw_clk_out), .sw_clk_oe(sw_clk_oe),
    .sw_data(sw_data), .sw_latch(sw_latch), .busy(busy)
  );

  assign link_clk = sw_clk_oe ? sw_clk_out : ext_clk;

  initial forever begin
    repeat (EXT_HALF) @(negedge clk);
    ext_clk = ext_run ? ~ext_clk : 1'b0;
  end

  // Receiver model of the power switch, sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (link_clk && !lc_prev) begin
      rx_sr = {rx_sr[9:0], sw_data};
      rise_data = sw_data;
      if (last_rise >= 0) rise_gap = cyc - last_rise;
      last_rise = cyc;
    end
    if (link_clk && lc_prev && sw_data !== rise_data) stable_viol++;
    if (!link_clk && lc_prev) high_len = cyc - last_rise;
    if (sw_latch && !latch_prev) begin
      fr_log[frames_seen % 8] = rx_sr;
      frames_seen++;
      lat_cnt = 0;
    end
    if (sw_latch) lat_cnt++;
    if (!sw_latch && latch_prev) latch_w = lat_cnt;
    lc_prev = link_clk;
    latch_prev = sw_latch;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_word(input logic [2:0] bv, input logic [1:0] bp,
                                           input logic [2:0] av, input logic [1:0] ap);
    logic [10:0] w;
    w = '0;
    w[1:0] = ap; w[4:2] = av; w[6:5] = bp; w[9:7] = bv; w[10] = 1'b0;
    return w;
  endfunction

  task automatic request(input logic [2:0] bv, input logic [1:0] bp,
                         input logic [2:0] av, input logic [1:0] ap);
    b_vcc = bv; b_vpp = bp; a_vcc = av; a_vpp = ap;
    req_valid = 1'b1;
    step(1);
    req_valid = 1'b0;
  endtask

  task automatic wait_frames_done(input int target);
    int n = 0;
    while ((frames_seen < target || sw_latch) && n < TMO) begin
      step(1);
      n++;
    end
    chk(n < TMO, "R5 frame completion timeout", n, TMO);
  endtask

  task automatic t_reset();
    chk(!sw_latch && !sw_data && !sw_clk_out && !sw_clk_oe && !busy, "R1 reset outputs",
        {sw_latch, sw_data, sw_clk_out, sw_clk_oe, busy}, 0);
  endtask

  task automatic t_clock_internal();
    clk_drive_en = 1'b1;
    step(4 * DIV);
    chk(sw_clk_oe == 1'b1, "R2 oe follows drive enable", sw_clk_oe, 1);
    chk(rise_gap == DIV, "R3 internal period", rise_gap, DIV);
    chk(high_len == DIV - DIV/2, "R3 internal high phase", high_len, DIV - DIV/2);
  endtask

  task automatic t_frame(input logic [2:0] bv, input logic [1:0] bp,
                         input logic [2:0] av, input logic [1:0] ap, input int lw);
    int base = frames_seen;
    int sv = stable_viol;
    request(bv, bp, av, ap);
    chk(busy == 1'b1, "R7 busy after request", busy, 1);
    wait_frames_done(base + 1);
    chk(fr_log[base % 8] == exp_word(bv, bp, av, ap), "R4 frame content",
        fr_log[base % 8], exp_word(bv, bp, av, ap));
    chk(latch_w == lw, "R5 latch width", latch_w, lw);
    chk(stable_viol == sv, "R6 data stable while clock high", stable_viol - sv, 0);
    chk(busy == 1'b0, "R7 busy clear after latch", busy, 0);
  endtask

  task automatic t_queue();
    int base = frames_seen;
    request(3'd1, 2'd1, 3'd2, 2'd2);
    step(120);
    request(3'd7, 2'd3, 3'd7, 2'd3);
    step(10);
    request(3'd5, 2'd0, 3'd3, 2'd1);
    wait_frames_done(base + 1);
    chk(busy == 1'b1, "R8 busy with held request", busy, 1);
    wait_frames_done(base + 2);
    chk(fr_log[base % 8] == exp_word(3'd1, 2'd1, 3'd2, 2'd2), "R8 first frame intact",
        fr_log[base % 8], exp_word(3'd1, 2'd1, 3'd2, 2'd2));
    chk(fr_log[(base + 1) % 8] == exp_word(3'd5, 2'd0, 3'd3, 2'd1), "R8 latest request wins",
        fr_log[(base + 1) % 8], exp_word(3'd5, 2'd0, 3'd3, 2'd1));
    step(20 * DIV);
    chk(frames_seen == base + 2, "R8 overwritten request not sent", frames_seen, base + 2);
  endtask

  task automatic t_idle_quiet();
    int base = frames_seen;
    step(10 * DIV);
    chk(frames_seen == base && !busy && !sw_latch, "R10 no frame without request",
        frames_seen - base, 0);
  endtask

  task automatic t_ext_mode();
    clk_drive_en = 1'b0;
    step(3);
    chk(sw_clk_oe == 1'b0 && sw_clk_out == 1'b0, "R2 pin released as input",
        {sw_clk_oe, sw_clk_out}, 0);
    ext_run = 1'b1;
    step(8 * EXT_HALF);
    t_frame(3'd6, 2'd2, 3'd1, 2'd3, 2 * EXT_HALF); // R9
    chk(sw_clk_out == 1'b0, "R9 internal clock idle in external mode", sw_clk_out, 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(negedge clk);
      wd++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(5);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_clock_internal();
    t_frame(3'd2, 2'd1, 3'd5, 2'd2, DIV);
    t_frame(3'd7, 2'd3, 3'd0, 2'd0, DIV);
    t_frame(3'd0, 2'd0, 3'd7, 2'd3, DIV);
    t_queue();
    t_idle_quiet();
    t_ext_mode();
    t_idle_quiet();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule